// File: doc/BRIEF.md
# CAN Command and Transmit-Request Controller

This block sits between a CPU-visible command strobe and the bit-level engine of a CAN node. Each write of the 8-bit command word lasts one cycle and is not stored. The block turns the write into lasting state. That state is a pending request per transmit buffer, plus a per-buffer mode: normal with automatic resend, single shot, or single shot with the receiver kept on. A command can also cancel requests that have not started, free the receive buffer, or clear the data-overrun flag.

Only one transmit buffer is offered to the transmitter at a time. The block raises a request with a one-hot buffer select and waits for a grant. It then treats that buffer as in progress until the transmitter reports done, error or lost arbitration. A receive-status flag is kept in step with an outside frame FIFO through a next-frame-available input and a pop strobe. All per-buffer flags are visible as status outputs.

Top module: `can_cmd_ctrl`

## Requirements
- R1: After reset, all per-buffer pending, single-shot, self-reception and complete flags are 0. tx_req, tx_busy, rx_full and rx_data_overrun are also 0.
- R2: Command bits: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-reception, 5+i select buffer i. A write with bit 0 or bit 4 set marks every selected buffer pending from the next cycle and clears that buffer's complete flag.
- R3: While no buffer is in progress and at least one is pending, tx_req is 1. tx_buf_sel is then one-hot on the lowest-index pending buffer.
- R4: tx_gnt while tx_req is 1 makes the selected buffer in progress: tx_busy is 1, tx_req is 0 and tx_buf_sel holds that buffer. This lasts until tx_done, tx_err or tx_arb_lost.
- R5: tx_done during progress clears that buffer's pending flag and sets its complete flag.
- R6: A normal-mode buffer that ends in tx_err or tx_arb_lost stays pending and is requested again.
- R7: A write with bits 0 and 1 both set gives single shot: the single-shot flag is set, and an error or lost arbitration clears pending without setting complete.
- R8: A write with bit 4 and without bit 1 sets both the self-reception and single-shot flags. tx_self_rx is 1 while that buffer is selected. With bits 0, 1 and 4 together the mode is plain single shot, with the self-reception flag 0.
- R9: A write with bit 1 and neither bit 0 nor bit 4 cancels pending, together with its mode flags, for each selected buffer that is not in progress. A buffer in progress is left unchanged.
- R10: A transmit or self-reception write that selects the buffer in progress has no effect on that buffer.
- R11: When rx_full is 0 and rx_next_avail is 1, rx_pop pulses and rx_full becomes 1. A release write with rx_full at 1 pulses rx_pop and keeps rx_full at 1 if rx_next_avail is 1; otherwise it clears rx_full.
- R12: A clear-overrun write clears rx_data_overrun. An rx_overrun pulse sets it, and the pulse wins when both occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_data | input | 8 | Command word |
| tx_req | output | 1 | Request to transmitter |
| tx_buf_sel | output | 3 | One-hot buffer offered or in progress |
| tx_self_rx | output | 1 | Keep receiver on for the selected frame |
| tx_gnt | input | 1 | Transmitter accepts the request |
| tx_done | input | 1 | Transmission succeeded (pulse) |
| tx_err | input | 1 | Transmission error (pulse) |
| tx_arb_lost | input | 1 | Arbitration lost (pulse) |
| rx_next_avail | input | 1 | Receive FIFO holds a frame |
| rx_pop | output | 1 | Take the next frame from the FIFO |
| rx_overrun | input | 1 | FIFO overflow event (pulse) |
| txb_pending | output | 3 | Per-buffer pending flags |
| txb_single | output | 3 | Per-buffer single-shot flags |
| txb_self_rx | output | 3 | Per-buffer self-reception flags |
| txb_complete | output | 3 | Per-buffer transmit-complete flags |
| tx_busy | output | 1 | A buffer is in progress |
| rx_full | output | 1 | Receive buffer holds a frame |
| rx_data_overrun | output | 1 | Data-overrun status |

## Verification
The hardest case to reach is an abort that arrives while one selected buffer is in progress and another selected buffer is still only pending. The stimulus queues two buffers, grants the higher-priority one, then writes an abort that selects both. It then checks that only the waiting buffer drops. Rewriting a buffer that is in progress, to show it is ignored, is reached the same way. The bench grants a single-shot buffer first and checks that its single-shot flag survives the conflicting write.

// File: rtl/can_cmd_pkg.sv
package can_cmd_pkg;
  // control bits that sit below the buffer select field
  localparam int CTL_BITS = 5;
  localparam int BIT_XMIT = 0;
  localparam int BIT_ABRT = 1;
  localparam int BIT_RREL = 2;
  localparam int BIT_COVR = 3;
  localparam int BIT_SELF = 4;

  typedef struct packed {
    logic self_rx;
    logic clr_ovr;
    logic rel_rx;
    logic abort;
    logic xmit;
  } cmd_ctl_t;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_cmd_pkg::*;
#(
  parameter int NUM_TXB = 3,
  localparam int CMD_W = CTL_BITS + NUM_TXB
) (
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  output logic [NUM_TXB-1:0] queue_o,
  output logic [NUM_TXB-1:0] single_o,
  output logic [NUM_TXB-1:0] selfrx_o,
  output logic [NUM_TXB-1:0] abort_o,
  output logic               rel_rx_o,
  output logic               clr_ovr_o
);
  cmd_ctl_t            ctl;
  logic [NUM_TXB-1:0]  sel;
  logic                do_queue;
  logic                do_abort;

  assign ctl      = cmd_data[CTL_BITS-1:0];
  assign sel      = cmd_data[CMD_W-1:CTL_BITS];
  assign do_queue = cmd_wr && (ctl.xmit || ctl.self_rx);
  assign do_abort = cmd_wr && ctl.abort && !ctl.xmit && !ctl.self_rx;

  genvar g;
  generate
    for (g = 0; g < NUM_TXB; g++) begin : g_dec
      assign queue_o[g]  = do_queue && sel[g];
      assign abort_o[g]  = do_abort && sel[g];
      assign single_o[g] = ctl.abort || ctl.self_rx;
      assign selfrx_o[g] = ctl.self_rx && !ctl.abort;
    end
  endgenerate

  assign rel_rx_o  = cmd_wr && ctl.rel_rx;
  assign clr_ovr_o = cmd_wr && ctl.clr_ovr;
endmodule

// File: rtl/can_txb_slot.sv
module can_txb_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic queue_i,
  input  logic single_i,
  input  logic selfrx_i,
  input  logic abort_i,
  input  logic in_prog_i,
  input  logic fin_ok_i,
  input  logic fin_fail_i,
  output logic pend_o,
  output logic single_o,
  output logic selfrx_o,
  output logic cmplt_o
);
  logic pend_q, single_q, selfrx_q, cmplt_q;
  logic pend_d, single_d, selfrx_d, cmplt_d;
  logic upd_en;

  assign upd_en = queue_i || abort_i || fin_ok_i || fin_fail_i;

  always_comb begin
    pend_d   = pend_q;
    single_d = single_q;
    selfrx_d = selfrx_q;
    cmplt_d  = cmplt_q;
    if (fin_ok_i) begin
      pend_d   = 1'b0;
      single_d = 1'b0;
      selfrx_d = 1'b0;
      cmplt_d  = 1'b1;
    end else if (fin_fail_i && single_q) begin
      pend_d   = 1'b0;
      single_d = 1'b0;
      selfrx_d = 1'b0;
    end else if (!in_prog_i) begin
      if (queue_i) begin
        pend_d   = 1'b1;
        single_d = single_i;
        selfrx_d = selfrx_i;
        cmplt_d  = 1'b0;
      end else if (abort_i && pend_q) begin
        pend_d   = 1'b0;
        single_d = 1'b0;
        selfrx_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      single_q <= 1'b0;
      selfrx_q <= 1'b0;
      cmplt_q  <= 1'b0;
    end else if (upd_en) begin
      pend_q   <= pend_d;
      single_q <= single_d;
      selfrx_q <= selfrx_d;
      cmplt_q  <= cmplt_d;
    end
  end

  assign pend_o   = pend_q;
  assign single_o = single_q;
  assign selfrx_o = selfrx_q;
  assign cmplt_o  = cmplt_q;

  AST_INPROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog_i && pend_q && !fin_ok_i && !fin_fail_i) |=> pend_q) else $error("in-progress buffer lost"); // R9
  AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_fail_i && single_q) |=> (!pend_q && !cmplt_q)) else $error("single shot resent"); // R7
  AST_OK_CMPLT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ok_i |=> (cmplt_q && !pend_q)) else $error("completion lost"); // R5
  AST_RETRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_fail_i && !single_q) |=> pend_q) else $error("retry dropped"); // R6
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter #(
  parameter int NUM_TXB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TXB-1:0] pend_i,
  input  logic               gnt_i,
  input  logic               done_i,
  input  logic               err_i,
  input  logic               arb_i,
  output logic               req_o,
  output logic [NUM_TXB-1:0] sel_o,
  output logic               busy_o,
  output logic [NUM_TXB-1:0] in_prog_o,
  output logic [NUM_TXB-1:0] fin_ok_o,
  output logic [NUM_TXB-1:0] fin_fail_o
);
  logic               busy_q, busy_d;
  logic [NUM_TXB-1:0] cur_q, cur_d;
  logic [NUM_TXB-1:0] pick;
  logic               take, end_ev, st_en;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_TXB - 1; i >= 0; i--) begin
      if (pend_i[i]) pick = NUM_TXB'(1) << i;
    end
  end

  assign req_o     = !busy_q && (|pend_i);
  assign take      = req_o && gnt_i;
  assign end_ev    = busy_q && (done_i || err_i || arb_i);
  assign sel_o     = busy_q ? cur_q : (req_o ? pick : '0);
  assign in_prog_o = busy_q ? cur_q : (take ? pick : '0);
  assign fin_ok_o   = (busy_q && done_i) ? cur_q : '0;
  assign fin_fail_o = (busy_q && !done_i && (err_i || arb_i)) ? cur_q : '0;
  assign st_en     = take || end_ev;

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    if (take) begin
      busy_d = 1'b1;
      cur_d  = pick;
    end else if (end_ev) begin
      busy_d = 1'b0;
      cur_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
    end
  end

  assign busy_o = busy_q;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $onehot(sel_o)) else $error("request select not one-hot"); // R3
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_o) else $error("request while busy"); // R4
  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy_q && $stable(sel_o))) else $error("grant not held"); // R4
  AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot(cur_q)) else $error("more than one in progress"); // R3
endmodule

// File: rtl/can_rx_status.sv
module can_rx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_rx_i,
  input  logic clr_ovr_i,
  input  logic next_avail_i,
  input  logic overrun_i,
  output logic pop_o,
  output logic full_o,
  output logic dor_o
);
  logic full_q, full_d, dor_q, dor_d;
  logic full_en, dor_en;

  always_comb begin
    full_d = full_q;
    pop_o  = 1'b0;
    if (!full_q) begin
      if (next_avail_i) begin
        full_d = 1'b1;
        pop_o  = 1'b1;
      end
    end else if (rel_rx_i) begin
      if (next_avail_i) begin
        pop_o = 1'b1;
      end else begin
        full_d = 1'b0;
      end
    end
  end

  assign dor_d   = overrun_i ? 1'b1 : 1'b0;
  assign dor_en  = overrun_i || clr_ovr_i;
  assign full_en = (full_d != full_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (full_en) begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dor_q <= 1'b0;
    end else if (dor_en) begin
      dor_q <= dor_d;
    end
  end

  assign full_o = full_q;
  assign dor_o  = dor_q;

  AST_RX_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_rx_i && full_q && !next_avail_i) |=> !full_q) else $error("release kept buffer"); // R11
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && next_avail_i) |=> full_q) else $error("frame not loaded"); // R11
  AST_DOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr_i && !overrun_i) |=> !dor_q) else $error("overrun not cleared"); // R12
  AST_DOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_i |=> dor_q) else $error("overrun not set"); // R12
endmodule

// File: rtl/can_cmd_ctrl.sv
module can_cmd_ctrl
  import can_cmd_pkg::*;
#(
  parameter int NUM_TXB = 3,
  localparam int CMD_W = CTL_BITS + NUM_TXB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  output logic               tx_req,
  output logic [NUM_TXB-1:0] tx_buf_sel,
  output logic               tx_self_rx,
  input  logic               tx_gnt,
  input  logic               tx_done,
  input  logic               tx_err,
  input  logic               tx_arb_lost,
  input  logic               rx_next_avail,
  output logic               rx_pop,
  input  logic               rx_overrun,
  output logic [NUM_TXB-1:0] txb_pending,
  output logic [NUM_TXB-1:0] txb_single,
  output logic [NUM_TXB-1:0] txb_self_rx,
  output logic [NUM_TXB-1:0] txb_complete,
  output logic               tx_busy,
  output logic               rx_full,
  output logic               rx_data_overrun
);
  logic [NUM_TXB-1:0] queue, single, selfrx, abort;
  logic [NUM_TXB-1:0] in_prog, fin_ok, fin_fail;
  logic               rel_rx, clr_ovr;

  can_cmd_decode #(.NUM_TXB(NUM_TXB)) u_dec (
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .queue_o   (queue),
    .single_o  (single),
    .selfrx_o  (selfrx),
    .abort_o   (abort),
    .rel_rx_o  (rel_rx),
    .clr_ovr_o (clr_ovr)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_TXB; g++) begin : g_slot
      can_txb_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .queue_i    (queue[g]),
        .single_i   (single[g]),
        .selfrx_i   (selfrx[g]),
        .abort_i    (abort[g]),
        .in_prog_i  (in_prog[g]),
        .fin_ok_i   (fin_ok[g]),
        .fin_fail_i (fin_fail[g]),
        .pend_o     (txb_pending[g]),
        .single_o   (txb_single[g]),
        .selfrx_o   (txb_self_rx[g]),
        .cmplt_o    (txb_complete[g])
      );
    end
  endgenerate

  can_tx_arbiter #(.NUM_TXB(NUM_TXB)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (txb_pending),
    .gnt_i      (tx_gnt),
    .done_i     (tx_done),
    .err_i      (tx_err),
    .arb_i      (tx_arb_lost),
    .req_o      (tx_req),
    .sel_o      (tx_buf_sel),
    .busy_o     (tx_busy),
    .in_prog_o  (in_prog),
    .fin_ok_o   (fin_ok),
    .fin_fail_o (fin_fail)
  );

  can_rx_status u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rel_rx_i     (rel_rx),
    .clr_ovr_i    (clr_ovr),
    .next_avail_i (rx_next_avail),
    .overrun_i    (rx_overrun),
    .pop_o        (rx_pop),
    .full_o       (rx_full),
    .dor_o        (rx_data_overrun)
  );

  assign tx_self_rx = |(tx_buf_sel & txb_self_rx);

  AST_SELF_RX_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_self_rx |-> (|(tx_buf_sel & txb_single))) else $error("self rx without single shot"); // R8
  AST_QUEUE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|(queue & ~in_prog)) |=> (|txb_pending)) else $error("queue write lost"); // R2
endmodule

// File: tb/can_cmd_ctrl_bench.sv
module can_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       cmd_wr;
  logic [7:0] cmd_data;
  logic       tx_req, tx_self_rx, tx_gnt, tx_done, tx_err, tx_arb_lost;
  logic [2:0] tx_buf_sel;
  logic       rx_next_avail, rx_pop, rx_overrun;
  logic [2:0] txb_pending, txb_single, txb_self_rx, txb_complete;
  logic       tx_busy, rx_full, rx_data_overrun;

  can_cmd_ctrl u_can_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .tx_req(tx_req), .tx_buf_sel(tx_buf_sel), .tx_self_rx(tx_self_rx),
    .tx_gnt(tx_gnt), .tx_done(tx_done), .tx_err(tx_err), .tx_arb_lost(tx_arb_lost),
    .rx_next_avail(rx_next_avail), .rx_pop(rx_pop), .rx_overrun(rx_overrun),
    .txb_pending(txb_pending), .txb_single(txb_single), .txb_self_rx(txb_self_rx),
    .txb_complete(txb_complete), .tx_busy(tx_busy), .rx_full(rx_full),
    .rx_data_overrun(rx_data_overrun)
  );

  // pend, single, selfrx, complete, busy, req, sel, self_rx out, rx_full, overrun
  typedef logic [19:0] exp_t;

  int    checks = 0;
  int    fails  = 0;
  bit    drv_done = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t mk(input logic [2:0] p, input logic [2:0] s, input logic [2:0] r,
                              input logic [2:0] c, input logic b, input logic q,
                              input logic [2:0] sl, input logic so, input logic f, input logic d);
    return {p, s, r, c, b, q, sl, so, f, d};
  endfunction

  function automatic exp_t observed();
    return {txb_pending, txb_single, txb_self_rx, txb_complete, tx_busy, tx_req,
            tx_buf_sel, tx_self_rx, rx_full, rx_data_overrun};
  endfunction

  // driver: applies one cycle of stimulus and pushes the state expected after the edge
  task automatic tick(input string tag, input logic wr, input logic [7:0] cmd,
                      input logic [3:0] txev, input logic avail, input logic ovr,
                      input exp_t e, input logic pop_e);
    @(negedge clk);
    cmd_wr        = wr;
    cmd_data      = cmd;
    tx_gnt        = txev[0];
    tx_done       = txev[1];
    tx_err        = txev[2];
    tx_arb_lost   = txev[3];
    rx_next_avail = avail;
    rx_overrun    = ovr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    checks++;
    if (rx_pop !== pop_e) begin
      fails++;
      $display("FAIL %s rx_pop actual=%b expected=%b", tag, rx_pop, pop_e);
    end
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (observed() !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, observed(), e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [3:0] EV_NONE = 4'b0000, EV_GNT = 4'b0001, EV_DONE = 4'b0010,
                         EV_ERR = 4'b0100, EV_ARB = 4'b1000;

  initial begin
    cmd_wr = 0; cmd_data = 0; tx_gnt = 0; tx_done = 0; tx_err = 0; tx_arb_lost = 0;
    rx_next_avail = 0; rx_overrun = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (observed() !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%h expected=%h", observed(), 20'h0);
    end

    // R2 R3: queue buffers 1 and 2 (bits 0,6,7)
    tick("R2_R3 queue b1 b2", 1, 8'hC1, EV_NONE, 0, 0, mk(3'b110,0,0,0,0,1,3'b010,0,0,0), 0);
    tick("R4 grant b1", 0, 0, EV_GNT, 0, 0, mk(3'b110,0,0,0,1,0,3'b010,0,0,0), 0);
    // R9: abort b1 and b2 while b1 in progress
    tick("R9 abort keeps in-progress", 1, 8'hC2, EV_NONE, 0, 0, mk(3'b010,0,0,0,1,0,3'b010,0,0,0), 0);
    tick("R6 error retries", 0, 0, EV_ERR, 0, 0, mk(3'b010,0,0,0,0,1,3'b010,0,0,0), 0);
    tick("R4 regrant b1", 0, 0, EV_GNT, 0, 0, mk(3'b010,0,0,0,1,0,3'b010,0,0,0), 0);
    tick("R5 done b1", 0, 0, EV_DONE, 0, 0, mk(3'b000,0,0,3'b010,0,0,3'b000,0,0,0), 0);

    // R7: single shot on b0
    tick("R7 single shot queue", 1, 8'h23, EV_NONE, 0, 0, mk(3'b001,3'b001,0,3'b010,0,1,3'b001,0,0,0), 0);
    tick("R7 grant b0", 0, 0, EV_GNT, 0, 0, mk(3'b001,3'b001,0,3'b010,1,0,3'b001,0,0,0), 0);
    tick("R10 requeue in-progress ignored", 1, 8'h21, EV_NONE, 0, 0, mk(3'b001,3'b001,0,3'b010,1,0,3'b001,0,0,0), 0);
    tick("R7 arb lost drops", 0, 0, EV_ARB, 0, 0, mk(3'b000,0,0,3'b010,0,0,3'b000,0,0,0), 0);

    // R8: self reception on b2
    tick("R8 self rx queue", 1, 8'h90, EV_NONE, 0, 0, mk(3'b100,3'b100,3'b100,3'b010,0,1,3'b100,1,0,0), 0);
    tick("R8 grant b2", 0, 0, EV_GNT, 0, 0, mk(3'b100,3'b100,3'b100,3'b010,1,0,3'b100,1,0,0), 0);
    tick("R8 done b2", 0, 0, EV_DONE, 0, 0, mk(3'b000,0,0,3'b110,0,0,3'b000,0,0,0), 0);
    tick("R8 all three bits plain single", 1, 8'h33, EV_NONE, 0, 0, mk(3'b001,3'b001,0,3'b110,0,1,3'b001,0,0,0), 0);
    tick("R9 abort pending b0", 1, 8'h22, EV_NONE, 0, 0, mk(3'b000,0,0,3'b110,0,0,3'b000,0,0,0), 0);

    // R3: priority across all three
    tick("R3 queue all", 1, 8'hE1, EV_NONE, 0, 0, mk(3'b111,0,0,0,0,1,3'b001,0,0,0), 0);
    tick("R3 grant b0", 0, 0, EV_GNT, 0, 0, mk(3'b111,0,0,0,1,0,3'b001,0,0,0), 0);
    tick("R3 done b0", 0, 0, EV_DONE, 0, 0, mk(3'b110,0,0,3'b001,0,1,3'b010,0,0,0), 0);
    tick("R3 grant b1", 0, 0, EV_GNT, 0, 0, mk(3'b110,0,0,3'b001,1,0,3'b010,0,0,0), 0);
    tick("R3 done b1", 0, 0, EV_DONE, 0, 0, mk(3'b100,0,0,3'b011,0,1,3'b100,0,0,0), 0);
    tick("R3 grant b2", 0, 0, EV_GNT, 0, 0, mk(3'b100,0,0,3'b011,1,0,3'b100,0,0,0), 0);
    tick("R3 done b2", 0, 0, EV_DONE, 0, 0, mk(3'b000,0,0,3'b111,0,0,3'b000,0,0,0), 0);

    // R11: receive buffer
    tick("R11 load frame", 0, 0, EV_NONE, 1, 0, mk(0,0,0,3'b111,0,0,0,0,1,0), 1);
    tick("R11 hold without release", 0, 0, EV_NONE, 1, 0, mk(0,0,0,3'b111,0,0,0,0,1,0), 0);
    tick("R11 release with next", 1, 8'h04, EV_NONE, 1, 0, mk(0,0,0,3'b111,0,0,0,0,1,0), 1);
    tick("R11 release empty", 1, 8'h04, EV_NONE, 0, 0, mk(0,0,0,3'b111,0,0,0,0,0,0), 0);

    // R12: overrun flag
    tick("R12 overrun set", 0, 0, EV_NONE, 0, 1, mk(0,0,0,3'b111,0,0,0,0,0,1), 0);
    tick("R12 clear", 1, 8'h08, EV_NONE, 0, 0, mk(0,0,0,3'b111,0,0,0,0,0,0), 0);
    tick("R12 set wins over clear", 1, 8'h08, EV_NONE, 0, 1, mk(0,0,0,3'b111,0,0,0,0,0,1), 0);
    tick("R12 clear again", 1, 8'h08, EV_NONE, 0, 0, mk(0,0,0,3'b111,0,0,0,0,0,0), 0);
    tick("idle", 0, 0, EV_NONE, 0, 0, mk(0,0,0,3'b111,0,0,0,0,0,0), 0);

    repeat (3) @(posedge clk);
    drv_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule